// File: doc/BRIEF.md
# Display Power-Up/Power-Down Sequencer

This block brings three display subsystems up and down in a strict order: the pixel clock, the sync generator and the display data path. Software, or a neighbouring controller, posts requests by writing a stage mask to one of two write-one-to-set command registers, one for switching stages on and one for switching them off. The sequencer then drives one request line per stage and waits for that stage's acknowledge before it touches the next one.

Acknowledges come back as levels that show whether a subsystem is really running. They pass through a synchroniser of one or two flops, and the result is the status vector. A request that would break the ordering stays pending until the stage it depends on has settled. A busy flag shows that work is in flight. A one-cycle done pulse marks the end of a complete power-up or a complete power-down.

Top module: `disp_seq_top`

## Requirements
- R1: After reset all stage requests, all status bits, busy and done are 0.
- R2: A stage's request rises only while the status bit of the stage below it is 1. The pixel clock is stage 0 and has no prerequisite, so enabling runs pixel clock, then sync, then display.
- R3: A stage's request falls only while the status bit of the stage above it is 0. The display is the top stage and has no prerequisite, so disabling runs display, then sync, then pixel clock.
- R4: A write with `cmd_sel`=0 posts enable requests and a write with `cmd_sel`=1 posts disable requests. Bit i of `cmd_bits` selects stage i: bit 0 is the pixel clock, bit 1 is sync and bit 2 is display. Zero bits have no effect.
- R5: An enable request whose prerequisite stage is off stays pending and changes no request line. It is carried out once the prerequisite reports running.
- R6: A status bit changes only as a copy of its acknowledge input, delayed by exactly SYNC_STAGES clock cycles.
- R7: At most one request line changes per cycle, and no further request line changes until the status of the stage in flight has reached its target.
- R8: `busy` is 1 while a request awaits its acknowledge or a pending request can be issued. While `busy` is 0, the request lines equal the status bits.
- R9: `seq_done` is a one-cycle pulse. It fires when the top stage's status reaches 1 or when stage 0's status reaches 0, and at no other completion.
- R10: Writing a bit to one command register cancels a pending request for the same stage in the other register. A request that asks for the state a stage is already requested to be in is dropped with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_sel | input | 1 | 0 selects the enable register, 1 selects the disable register |
| cmd_bits | input | NSTAGE | Write-one-to-set stage mask |
| stage_req | output | NSTAGE | Request level to each subsystem |
| stage_ack | input | NSTAGE | Running level from each subsystem |
| stat_bits | output | NSTAGE | Synchronised running status per stage |
| busy | output | 1 | A transition is in flight or can be issued |
| seq_done | output | 1 | Pulse at the end of a full power-up or power-down |

## Verification
The bench builds the block with NSTAGE=3 and SYNC_STAGES=2, so the two-flop synchroniser variant and its two-cycle status lag are both checked. Subsystem models acknowledge after 4, 6 and 8 cycles for stages 0, 1 and 2. Because these delays differ, a stage issued before its prerequisite has settled would show up as an out-of-order request edge. Three stages are enough to cover a request held behind an off prerequisite, a cancelled request, a dropped redundant request, and a partial power-up that must not raise the done pulse.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } sq_state_e;
endpackage

// File: rtl/disp_seq_cmd.sv
module disp_seq_cmd #(
   parameter int NSTAGE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [NSTAGE-1:0] bits,
   input  logic [NSTAGE-1:0] clr_en,
   input  logic [NSTAGE-1:0] clr_dis,
   output logic [NSTAGE-1:0] pend_en,
   output logic [NSTAGE-1:0] pend_dis
);
   logic [NSTAGE-1:0] set_en, set_dis;

   assign set_en  = (wr && !sel) ? bits : '0;
   assign set_dis = (wr &&  sel) ? bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_en  <= '0;
         pend_dis <= '0;
      end else begin
         pend_en  <= set_en  | (pend_en  & ~clr_en  & ~set_dis);
         pend_dis <= set_dis | (pend_dis & ~clr_dis & ~set_en);
      end
   end

   // R10
   excl_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_en & pend_dis) == '0);
endmodule

// File: rtl/disp_seq_sync.sv
module disp_seq_sync #(
   parameter int NSTAGE      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSTAGE-1:0] ack,
   output logic [NSTAGE-1:0] status
);
   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) status <= '0;
            else        status <= ack;
         end
      end else begin : g_two
         logic [NSTAGE-1:0] meta;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta   <= '0;
               status <= '0;
            end else begin
               meta   <= ack;
               status <= meta;
            end
         end
      end
   endgenerate

   // R6
   status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> (status == $past(ack, SYNC_STAGES)));
endmodule

// File: rtl/disp_seq_arb.sv
module disp_seq_arb #(
   parameter int NSTAGE = 3,
   localparam int IW    = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
   input  logic [NSTAGE-1:0] pend_en,
   input  logic [NSTAGE-1:0] pend_dis,
   input  logic [NSTAGE-1:0] req,
   input  logic [NSTAGE-1:0] status,
   output logic              pick_vld,
   output logic [IW-1:0]     pick_idx,
   output logic              pick_lvl,
   output logic [NSTAGE-1:0] drop_en,
   output logic [NSTAGE-1:0] drop_dis
);
   logic [NSTAGE-1:0] ok_en, ok_dis;

   assign drop_en  = pend_en  &  req;
   assign drop_dis = pend_dis & ~req;

   for (genvar g = 0; g < NSTAGE; g++) begin : g_ok
      if (g == 0) begin : g_lo
         assign ok_en[g] = pend_en[g] & ~req[g];
      end else begin : g_lo
         assign ok_en[g] = pend_en[g] & ~req[g] & status[g-1];
      end
      if (g == NSTAGE-1) begin : g_hi
         assign ok_dis[g] = pend_dis[g] & req[g];
      end else begin : g_hi
         assign ok_dis[g] = pend_dis[g] & req[g] & ~status[g+1];
      end
   end

   // disables take priority, highest stage first; enables lowest stage first
   always_comb begin
      pick_vld = 1'b0;
      pick_idx = '0;
      pick_lvl = 1'b0;
      for (int i = NSTAGE-1; i >= 0; i--) begin
         if (ok_en[i]) begin
            pick_vld = 1'b1;
            pick_idx = IW'(i);
            pick_lvl = 1'b1;
         end
      end
      for (int i = 0; i < NSTAGE; i++) begin
         if (ok_dis[i]) begin
            pick_vld = 1'b1;
            pick_idx = IW'(i);
            pick_lvl = 1'b0;
         end
      end
   end
endmodule

// File: rtl/disp_seq_fsm.sv
module disp_seq_fsm
   import disp_seq_pkg::*;
#(
   parameter int NSTAGE = 3,
   localparam int IW    = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pick_vld,
   input  logic [IW-1:0]     pick_idx,
   input  logic              pick_lvl,
   input  logic [NSTAGE-1:0] drop_en,
   input  logic [NSTAGE-1:0] drop_dis,
   input  logic [NSTAGE-1:0] status,
   output logic [NSTAGE-1:0] req,
   output logic [NSTAGE-1:0] clr_en,
   output logic [NSTAGE-1:0] clr_dis,
   output logic              busy,
   output logic              done
);
   sq_state_e         state;
   logic [IW-1:0]     idx;
   logic              lvl;
   logic [NSTAGE-1:0] issue_vec;
   logic              issue;

   assign issue     = (state == SQ_IDLE) && pick_vld;
   assign issue_vec = issue ? (NSTAGE'(1) << pick_idx) : '0;
   assign clr_en    = drop_en  | (pick_lvl  ? issue_vec : '0);
   assign clr_dis   = drop_dis | (!pick_lvl ? issue_vec : '0);
   assign busy      = (state == SQ_WAIT) || pick_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         idx   <= '0;
         lvl   <= 1'b0;
         req   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SQ_IDLE: if (pick_vld) begin
               req[pick_idx] <= pick_lvl;
               idx           <= pick_idx;
               lvl           <= pick_lvl;
               state         <= SQ_WAIT;
            end
            SQ_WAIT: if (status[idx] == lvl) begin
               state <= SQ_IDLE;
               done  <= (lvl && idx == IW'(NSTAGE-1)) || (!lvl && idx == '0);
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R7
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req ^ $past(req)) <= 1);
   // R8
   issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != $past(req)) |=> busy);
   // R8
   idle_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (req == status));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   for (genvar g = 1; g < NSTAGE; g++) begin : g_en_ord
      // R2
      en_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req[g]) |-> status[g-1]);
   end
   for (genvar g = 0; g < NSTAGE-1; g++) begin : g_dis_ord
      // R3
      dis_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(req[g]) |-> !status[g+1]);
   end
endmodule

// File: rtl/disp_seq_top.sv
module disp_seq_top #(
   parameter int NSTAGE      = 3,
   parameter int SYNC_STAGES = 2,
   localparam int IW         = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              cmd_sel,
   input  logic [NSTAGE-1:0] cmd_bits,
   output logic [NSTAGE-1:0] stage_req,
   input  logic [NSTAGE-1:0] stage_ack,
   output logic [NSTAGE-1:0] stat_bits,
   output logic              busy,
   output logic              seq_done
);
   if (NSTAGE < 2 || NSTAGE > 8) begin : g_bad_nstage
      $error("disp_seq_top: NSTAGE must lie in 2..8");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
      $error("disp_seq_top: SYNC_STAGES must be 1 or 2");
   end

   logic [NSTAGE-1:0] pend_en, pend_dis, clr_en, clr_dis, drop_en, drop_dis;
   logic              pick_vld, pick_lvl;
   logic [IW-1:0]     pick_idx;

   disp_seq_cmd #(.NSTAGE(NSTAGE)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .sel(cmd_sel), .bits(cmd_bits),
      .clr_en(clr_en), .clr_dis(clr_dis), .pend_en(pend_en), .pend_dis(pend_dis)
   );

   disp_seq_sync #(.NSTAGE(NSTAGE), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ack(stage_ack), .status(stat_bits)
   );

   disp_seq_arb #(.NSTAGE(NSTAGE)) u_arb (
      .pend_en(pend_en), .pend_dis(pend_dis), .req(stage_req), .status(stat_bits),
      .pick_vld(pick_vld), .pick_idx(pick_idx), .pick_lvl(pick_lvl),
      .drop_en(drop_en), .drop_dis(drop_dis)
   );

   disp_seq_fsm #(.NSTAGE(NSTAGE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pick_vld(pick_vld), .pick_idx(pick_idx),
      .pick_lvl(pick_lvl), .drop_en(drop_en), .drop_dis(drop_dis),
      .status(stat_bits), .req(stage_req), .clr_en(clr_en), .clr_dis(clr_dis),
      .busy(busy), .done(seq_done)
   );
endmodule

// File: tb/sim_disp_seq_top.sv
`timescale 1ns/1ps
module sim_disp_seq_top;
   localparam int N    = 3;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_wr = 1'b0;
   logic         cmd_sel = 1'b0;
   logic [N-1:0] cmd_bits = '0;
   logic [N-1:0] stage_req, stage_ack, stat_bits;
   logic         busy, seq_done;

   always #2 clk = ~clk;

   disp_seq_top #(.NSTAGE(N), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
      .cmd_bits(cmd_bits), .stage_req(stage_req), .stage_ack(stage_ack),
      .stat_bits(stat_bits), .busy(busy), .seq_done(seq_done)
   );

   // subsystem models: ack follows req after 4 + 2*stage cycles
   int ack_cnt [N];
   always @(posedge clk) begin
      for (int s = 0; s < N; s++) begin
         if (!rst_n) begin
            stage_ack[s] <= 1'b0;
            ack_cnt[s]   <= 0;
         end else if (stage_req[s] != stage_ack[s]) begin
            if (ack_cnt[s] == 4 + 2*s - 1) begin
               stage_ack[s] <= stage_req[s];
               ack_cnt[s]   <= 0;
            end else begin
               ack_cnt[s] <= ack_cnt[s] + 1;
            end
         end else begin
            ack_cnt[s] <= 0;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   typedef struct {
      int    stg;
      logic  lvl;
      string tag;
   } ev_t;
   ev_t exp_q[$];

   task automatic push(input int s, input logic l, input string tag);
      ev_t e;
      e.stg = s; e.lvl = l; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: pops expected request edges, counts done pulses, times status lag
   logic [N-1:0] prev_req = '0;
   logic         prev_ack0 = 1'b0;
   logic         prev_st0 = 1'b0;
   int cyc = 0;
   int done_cnt = 0;
   int ack0_rise = -1;
   int st0_rise = -1;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (seq_done) done_cnt++;
         if (stage_ack[0] && !prev_ack0) ack0_rise = cyc;
         if (stat_bits[0] && !prev_st0)  st0_rise  = cyc;
         for (int s = 0; s < N; s++) begin
            if (stage_req[s] != prev_req[s]) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5 unexpected request edge", s, -1);
               end else begin
                  ev_t e;
                  e = exp_q.pop_front();
                  chk(e.stg == s && e.lvl == stage_req[s], e.tag,
                      s * 2 + int'(stage_req[s]), e.stg * 2 + int'(e.lvl));
               end
            end
         end
      end
      prev_req  = stage_req;
      prev_ack0 = stage_ack[0];
      prev_st0  = stat_bits[0];
   end

   task automatic cmd(input logic sel, input logic [N-1:0] b);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_sel = sel; cmd_bits = b;
      @(negedge clk);
      cmd_wr = 1'b0; cmd_bits = '0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(stage_req == '0 && stat_bits == '0, "R1 req/status", {stage_req, stat_bits}, 0);
      chk(!busy && !seq_done, "R1 busy/done", {busy, seq_done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(stage_req == '0 && !busy, "R1 after release", {busy, stage_req}, 0);

      // R5: display enable with sync off is held
      cmd(1'b0, 3'b100);
      repeat (40) @(negedge clk);
      chk(!busy, "R5 held request not busy", busy, 0);
      chk(stage_req == '0, "R5 held request lines", stage_req, 0);

      // R2/R4: enable clock and sync; held display follows
      push(0, 1'b1, "R2 enable step clock");
      push(1, 1'b1, "R2 enable step sync");
      push(2, 1'b1, "R5 held display released");
      cmd(1'b0, 3'b011);
      chk(busy, "R8 busy after enable write", busy, 1);
      wait_idle();
      chk(stat_bits == 3'b111, "R2 all running", stat_bits, 7);
      chk(done_cnt == 1, "R9 done after full enable", done_cnt, 1);
      chk(exp_q.size() == 0, "R7 enable edges consumed", exp_q.size(), 0);

      // R10: redundant enable dropped
      cmd(1'b0, 3'b001);
      repeat (20) @(negedge clk);
      chk(!busy && stage_req == 3'b111, "R10 redundant enable", {busy, stage_req}, 7);

      // R3: full disable
      push(2, 1'b0, "R3 disable step display");
      push(1, 1'b0, "R3 disable step sync");
      push(0, 1'b0, "R3 disable step clock");
      cmd(1'b1, 3'b111);
      wait_idle();
      chk(stat_bits == '0, "R3 all stopped", stat_bits, 0);
      chk(done_cnt == 2, "R9 done after full disable", done_cnt, 2);

      // R10: cancel held enables via disable register, then partial enable
      cmd(1'b0, 3'b110);
      repeat (5) @(negedge clk);
      cmd(1'b1, 3'b110);
      repeat (5) @(negedge clk);
      push(0, 1'b1, "R10 only clock after cancel");
      cmd(1'b0, 3'b001);
      wait_idle();
      repeat (40) @(negedge clk);
      chk(stat_bits == 3'b001, "R10 cancel left only clock", stat_bits, 1);
      chk(done_cnt == 2, "R9 no done on partial enable", done_cnt, 2);
      chk(st0_rise - ack0_rise == SYNC, "R6 status lag", st0_rise - ack0_rise, SYNC);

      // R4: zero mask write has no effect
      cmd(1'b1, 3'b000);
      repeat (10) @(negedge clk);
      chk(!busy && stage_req == 3'b001, "R4 zero mask", {busy, stage_req}, 1);

      push(0, 1'b0, "R3 single clock disable");
      cmd(1'b1, 3'b001);
      wait_idle();
      chk(stat_bits == '0, "R3 clock stopped", stat_bits, 0);
      chk(done_cnt == 3, "R9 done on stage 0 off", done_cnt, 3);
      chk(exp_q.size() == 0, "R7 all edges consumed", exp_q.size(), 0);
      finish_up();
   end
endmodule